// File: doc/BRIEF.md
# DMA Controller Register File with Ring Restart and Grouped Interrupts

This block is the software-visible register file of an Ethernet DMA controller that serves several transmit and several receive descriptor rings. A simple word-oriented register bus reads and writes it. Each register follows its own access rule: read/write, read-only, write-only or write-one-to-clear. Read data is returned combinationally while the bus enable is high. The DMA engine reports events and ring halts through set pulses. Software acknowledges them by writing ones.

A single event register and a mask register together drive three interrupt lines, for transmit, receive and error. Each line covers a fixed group of event bits. Clearing the halt flag of a ring produces a one-cycle restart pulse for that ring. Transmit rings pulse on every clearing write. Receive rings pulse only when a one lands on a flag that already reads zero. Writing a ring's base register stores an 8-byte aligned address and loads the same value into that ring's current pointer, which the descriptor engine consumes.

Top module: `dmac_regfile`

## Requirements
- R1: A synchronous reset clears every register except the identity word and drops all interrupt and restart outputs. The first cycle after reset reads the identity word ID_VALUE at index 6.
- R2: The event register at index 0 clears each bit written with a one. A high `evt_set` bit sets its event bit at the next edge, and a set wins over a same-cycle clear of that bit.
- R3: The mask register at index 1 is read/write. `tx_irq`, `rx_irq` and `err_irq` are the OR of event AND mask over the groups TX_GRP (default bits 7:0), RX_GRP (bits 15:8) and ERR_GRP (bits 31:16). Each line follows a register change in the cycle after the write edge.
- R4: The transmit status word at index 3 holds the halt flag of transmit ring i at bit 31-i. `tx_halt_set[i]` sets the flag and writing a one clears it. Every such written one raises `tx_restart[i]` for exactly the one cycle after the write edge.
- R5: The receive status word at index 4 holds the halt flag of receive ring i at bit 23-i and clears on a written one. `rx_restart[i]` pulses for one cycle only when a one is written to that bit while it reads zero.
- R6: Writing transmit base index 8+i or receive base index 24+i stores the data with bits 2:0 forced to zero. The same value is copied into the current pointer at index 16+i or 32+i, respectively. The pointers are read-only from the bus and appear on `tx_ring_ptr` and `rx_ring_ptr`, 32 bits per ring with ring 0 lowest.
- R7: The control word at index 2 is read/write and drives `ctrl_word`. The command word at index 5 is write-only: it drives `cmd_word` and reads as zero.
- R8: Writes to the identity word, to the pointer indices and to unmapped indices change nothing. Unmapped indices, including ring slots at or above NUM_RINGS, read zero.
- R9: The register index is the byte address shifted right by two. Address bits 1:0 are ignored on reads and writes.
- R10: A halt set pulse and a same-cycle clearing write to the same flag leave the flag set. The transmit restart pulse is still emitted in that case.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_en | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | BUS_AW | Byte address of the word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, zero when bus_en is low |
| evt_set | input | 32 | Event set pulses from the DMA engine |
| tx_halt_set | input | NUM_RINGS | Transmit ring halt set pulses |
| rx_halt_set | input | NUM_RINGS | Receive ring halt set pulses |
| tx_irq | output | 1 | Transmit interrupt |
| rx_irq | output | 1 | Receive interrupt |
| err_irq | output | 1 | Error interrupt |
| tx_restart | output | NUM_RINGS | One-cycle transmit ring restart pulses |
| rx_restart | output | NUM_RINGS | One-cycle receive ring restart pulses |
| tx_ring_ptr | output | 32*NUM_RINGS | Transmit current pointers |
| rx_ring_ptr | output | 32*NUM_RINGS | Receive current pointers |
| ctrl_word | output | 32 | Control register contents |
| cmd_word | output | 32 | Command register contents |

## Verification
The bench builds the block with its defaults: eight rings, an 8-bit byte address and the default interrupt groups. With eight rings every halt bit position in both status words is live, and every base and pointer slot in the 8-slot windows can be reached. The three groups together span all 32 event bits, so any event that is set and unmasked reaches exactly one line. Directed sequences drive the set-versus-clear collisions and the zero-flag receive restart. A seeded random phase then mixes writes to every index with engine pulses.

// File: rtl/dmac_pkg.sv
package dmac_pkg;
  localparam int REG_W = 32;

  // word indices of the fixed registers
  localparam int IX_EVT  = 0;
  localparam int IX_MSK  = 1;
  localparam int IX_CTRL = 2;
  localparam int IX_TXST = 3;
  localparam int IX_RXST = 4;
  localparam int IX_CMD  = 5;
  localparam int IX_ID   = 6;

  // 8-slot ring windows, selected by index bits above bit 2
  localparam int GR_TXBASE = 1;
  localparam int GR_TXPTR  = 2;
  localparam int GR_RXBASE = 3;
  localparam int GR_RXPTR  = 4;
  localparam int RING_SLOTS = 8;

  // halt flag of ring i sits at TOP-i
  localparam int TX_HALT_TOP = 31;
  localparam int RX_HALT_TOP = 23;

  function automatic logic [REG_W-1:0] align_ptr(input logic [REG_W-1:0] v);
    return {v[REG_W-1:3], 3'b000};
  endfunction

  function automatic logic group_hit(input logic [REG_W-1:0] ev,
                                     input logic [REG_W-1:0] mk,
                                     input logic [REG_W-1:0] grp);
    return |(ev & mk & grp);
  endfunction
endpackage

// File: rtl/dmac_w1c_bits.sv
module dmac_w1c_bits #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] clr,
  input  logic [W-1:0] set,
  output logic [W-1:0] q
);
  // a set pulse overrides a clear of the same bit
  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= (q & ~clr) | set;
  end
endmodule

// File: rtl/dmac_halt_ctl.sv
module dmac_halt_ctl #(
  parameter int N             = 8,
  parameter int TOP_BIT       = 31,
  parameter bit PULSE_IF_IDLE = 1'b0
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        wr,
  input  logic [31:0] wdata,
  input  logic [N-1:0] set,
  output logic [N-1:0] restart,
  output logic [31:0] stat_word
);
  logic [N-1:0] halt_q;
  logic [N-1:0] clr;
  logic [N-1:0] pick;
  logic         unused_wdata;

  assign unused_wdata = ^wdata;

  for (genvar i = 0; i < N; i++) begin : g_ring
    assign clr[i] = wr & wdata[TOP_BIT-i];
    if (PULSE_IF_IDLE) begin : g_idle
      assign pick[i] = clr[i] & ~halt_q[i];
    end else begin : g_any
      assign pick[i] = clr[i];
    end
  end

  dmac_w1c_bits #(.W(N)) u_flags (
    .clk(clk), .rst(rst), .clr(clr), .set(set), .q(halt_q)
  );

  always_ff @(posedge clk) begin
    if (rst) restart <= '0;
    else     restart <= pick;
  end

  always_comb begin
    stat_word = '0;
    for (int i = 0; i < N; i++) stat_word[TOP_BIT-i] = halt_q[i];
  end
endmodule

// File: rtl/dmac_ring_ptrs.sv
module dmac_ring_ptrs
  import dmac_pkg::*;
#(
  parameter int N = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N-1:0]      base_we,
  input  logic [REG_W-1:0]  wdata,
  output logic [N*REG_W-1:0] base_flat,
  output logic [N*REG_W-1:0] ptr_flat
);
  for (genvar i = 0; i < N; i++) begin : g_ring
    logic [REG_W-1:0] base_q;
    logic [REG_W-1:0] ptr_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        base_q <= '0;
        ptr_q  <= '0;
      end else if (base_we[i]) begin
        base_q <= align_ptr(wdata);
        ptr_q  <= align_ptr(wdata);
      end
    end
    assign base_flat[i*REG_W +: REG_W] = base_q;
    assign ptr_flat[i*REG_W +: REG_W]  = ptr_q;
  end
endmodule

// File: rtl/dmac_regfile.sv
module dmac_regfile
  import dmac_pkg::*;
#(
  parameter int          NUM_RINGS = 8,
  parameter int          BUS_AW    = 8,
  parameter logic [31:0] TX_GRP    = 32'h0000_00FF,
  parameter logic [31:0] RX_GRP    = 32'h0000_FF00,
  parameter logic [31:0] ERR_GRP   = 32'hFFFF_0000,
  parameter logic [31:0] ID_VALUE  = 32'h4D41_0100
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       bus_en,
  input  logic                       bus_we,
  input  logic [BUS_AW-1:0]          bus_addr,
  input  logic [31:0]                bus_wdata,
  output logic [31:0]                bus_rdata,
  input  logic [31:0]                evt_set,
  input  logic [NUM_RINGS-1:0]       tx_halt_set,
  input  logic [NUM_RINGS-1:0]       rx_halt_set,
  output logic                       tx_irq,
  output logic                       rx_irq,
  output logic                       err_irq,
  output logic [NUM_RINGS-1:0]       tx_restart,
  output logic [NUM_RINGS-1:0]       rx_restart,
  output logic [32*NUM_RINGS-1:0]    tx_ring_ptr,
  output logic [32*NUM_RINGS-1:0]    rx_ring_ptr,
  output logic [31:0]                ctrl_word,
  output logic [31:0]                cmd_word
);
  localparam int IDX_W = BUS_AW - 2;
  localparam int GRP_W = IDX_W - 3;

  // decoded access, named for the checker
  logic [IDX_W-1:0] acc_idx;
  logic [GRP_W-1:0] acc_grp;
  logic [2:0]       acc_ring;
  logic             ring_ok;
  logic             wr_stb;
  logic             unused_addr_lo;

  assign acc_idx        = bus_addr[BUS_AW-1:2];
  assign acc_grp        = acc_idx[IDX_W-1:3];
  assign acc_ring       = acc_idx[2:0];
  assign ring_ok        = int'(acc_ring) < NUM_RINGS;
  assign wr_stb         = bus_en & bus_we;
  assign unused_addr_lo = ^bus_addr[1:0];

  logic wr_evt, wr_txst, wr_rxst;
  assign wr_evt  = wr_stb && (acc_idx == IDX_W'(IX_EVT));
  assign wr_txst = wr_stb && (acc_idx == IDX_W'(IX_TXST));
  assign wr_rxst = wr_stb && (acc_idx == IDX_W'(IX_RXST));

  // event register
  logic [31:0] evt_q;
  dmac_w1c_bits #(.W(32)) u_evt (
    .clk(clk), .rst(rst),
    .clr(wr_evt ? bus_wdata : 32'h0),
    .set(evt_set),
    .q(evt_q)
  );

  // plain read/write and write-only words
  logic [31:0] msk_q;
  always_ff @(posedge clk) begin
    if (rst) begin
      msk_q     <= '0;
      ctrl_word <= '0;
      cmd_word  <= '0;
    end else if (wr_stb) begin
      if (acc_idx == IDX_W'(IX_MSK))  msk_q     <= bus_wdata;
      if (acc_idx == IDX_W'(IX_CTRL)) ctrl_word <= bus_wdata;
      if (acc_idx == IDX_W'(IX_CMD))  cmd_word  <= bus_wdata;
    end
  end

  // ring halt flags and restart pulses
  logic [31:0] tx_stat_word, rx_stat_word;

  dmac_halt_ctl #(.N(NUM_RINGS), .TOP_BIT(TX_HALT_TOP), .PULSE_IF_IDLE(1'b0)) u_tx_halt (
    .clk(clk), .rst(rst), .wr(wr_txst), .wdata(bus_wdata),
    .set(tx_halt_set), .restart(tx_restart), .stat_word(tx_stat_word)
  );

  dmac_halt_ctl #(.N(NUM_RINGS), .TOP_BIT(RX_HALT_TOP), .PULSE_IF_IDLE(1'b1)) u_rx_halt (
    .clk(clk), .rst(rst), .wr(wr_rxst), .wdata(bus_wdata),
    .set(rx_halt_set), .restart(rx_restart), .stat_word(rx_stat_word)
  );

  // ring base / pointer pairs
  logic [NUM_RINGS-1:0] tx_base_we, rx_base_we;
  for (genvar i = 0; i < NUM_RINGS; i++) begin : g_we
    assign tx_base_we[i] = wr_stb && (int'(acc_grp) == GR_TXBASE) && (int'(acc_ring) == i);
    assign rx_base_we[i] = wr_stb && (int'(acc_grp) == GR_RXBASE) && (int'(acc_ring) == i);
  end

  logic [32*NUM_RINGS-1:0] tx_base_flat, rx_base_flat;

  dmac_ring_ptrs #(.N(NUM_RINGS)) u_tx_ring (
    .clk(clk), .rst(rst), .base_we(tx_base_we), .wdata(bus_wdata),
    .base_flat(tx_base_flat), .ptr_flat(tx_ring_ptr)
  );

  dmac_ring_ptrs #(.N(NUM_RINGS)) u_rx_ring (
    .clk(clk), .rst(rst), .base_we(rx_base_we), .wdata(bus_wdata),
    .base_flat(rx_base_flat), .ptr_flat(rx_ring_ptr)
  );

  // grouped interrupts
  assign tx_irq  = group_hit(evt_q, msk_q, TX_GRP);
  assign rx_irq  = group_hit(evt_q, msk_q, RX_GRP);
  assign err_irq = group_hit(evt_q, msk_q, ERR_GRP);

  // read mux
  logic [31:0] rd_val;
  always_comb begin
    rd_val = '0;
    if (acc_idx == IDX_W'(IX_EVT))       rd_val = evt_q;
    else if (acc_idx == IDX_W'(IX_MSK))  rd_val = msk_q;
    else if (acc_idx == IDX_W'(IX_CTRL)) rd_val = ctrl_word;
    else if (acc_idx == IDX_W'(IX_TXST)) rd_val = tx_stat_word;
    else if (acc_idx == IDX_W'(IX_RXST)) rd_val = rx_stat_word;
    else if (acc_idx == IDX_W'(IX_ID))   rd_val = ID_VALUE;
    else if (ring_ok) begin
      case (int'(acc_grp))
        GR_TXBASE: rd_val = tx_base_flat[int'(acc_ring)*32 +: 32];
        GR_TXPTR:  rd_val = tx_ring_ptr[int'(acc_ring)*32 +: 32];
        GR_RXBASE: rd_val = rx_base_flat[int'(acc_ring)*32 +: 32];
        GR_RXPTR:  rd_val = rx_ring_ptr[int'(acc_ring)*32 +: 32];
        default:   rd_val = '0;
      endcase
    end
  end

  assign bus_rdata = bus_en ? rd_val : 32'h0;
endmodule

// File: rtl/dmac_regfile_chk.sv
module dmac_regfile_chk #(
  parameter int NUM_RINGS = 8,
  parameter int BUS_AW    = 8
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    wr_stb,
  input logic [BUS_AW-3:0]       acc_idx,
  input logic [31:0]             bus_wdata,
  input logic [31:0]             evt_set,
  input logic [31:0]             evt_q,
  input logic                    tx_irq,
  input logic                    rx_irq,
  input logic                    err_irq,
  input logic [NUM_RINGS-1:0]    tx_restart,
  input logic [NUM_RINGS-1:0]    rx_restart,
  input logic [31:0]             rx_stat_word,
  input logic [NUM_RINGS-1:0]    tx_base_we,
  input logic [NUM_RINGS-1:0]    rx_base_we,
  input logic [32*NUM_RINGS-1:0] tx_ring_ptr,
  input logic [32*NUM_RINGS-1:0] rx_ring_ptr
);
  localparam int IDX_W = BUS_AW - 2;

  assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!tx_irq && !rx_irq && !err_irq && tx_restart == '0 && rx_restart == '0));

  assert_evt_full_clear_R2: assert property (@(posedge clk) disable iff (rst)
    (wr_stb && acc_idx == IDX_W'(0) && bus_wdata == 32'hFFFF_FFFF && evt_set == 32'h0)
    |=> evt_q == 32'h0);

  assert_evt_set_wins_R2: assert property (@(posedge clk) disable iff (rst)
    (evt_set != 32'h0) |=> ((evt_q & $past(evt_set)) == $past(evt_set)));

  assert_tx_pulse_needs_write_R4: assert property (@(posedge clk) disable iff (rst)
    !(wr_stb && acc_idx == IDX_W'(3)) |=> tx_restart == '0);

  assert_rx_pulse_needs_write_R5: assert property (@(posedge clk) disable iff (rst)
    !(wr_stb && acc_idx == IDX_W'(4)) |=> rx_restart == '0);

  for (genvar i = 0; i < NUM_RINGS; i++) begin : g_ring
    assert_rx_pulse_only_idle_R5: assert property (@(posedge clk) disable iff (rst)
      rx_restart[i] |-> !$past(rx_stat_word[23-i]));

    assert_tx_ptr_load_R6: assert property (@(posedge clk) disable iff (rst)
      tx_base_we[i] |=> tx_ring_ptr[i*32 +: 32] == {$past(bus_wdata[31:3]), 3'b000});

    assert_rx_ptr_load_R6: assert property (@(posedge clk) disable iff (rst)
      rx_base_we[i] |=> rx_ring_ptr[i*32 +: 32] == {$past(bus_wdata[31:3]), 3'b000});
  end
endmodule

bind dmac_regfile dmac_regfile_chk #(.NUM_RINGS(NUM_RINGS), .BUS_AW(BUS_AW)) u_chk (
  .clk(clk), .rst(rst), .wr_stb(wr_stb), .acc_idx(acc_idx), .bus_wdata(bus_wdata),
  .evt_set(evt_set), .evt_q(evt_q), .tx_irq(tx_irq), .rx_irq(rx_irq), .err_irq(err_irq),
  .tx_restart(tx_restart), .rx_restart(rx_restart), .rx_stat_word(rx_stat_word),
  .tx_base_we(tx_base_we), .rx_base_we(rx_base_we),
  .tx_ring_ptr(tx_ring_ptr), .rx_ring_ptr(rx_ring_ptr)
);

// File: tb/tb_dmac_regfile.sv
module tb_dmac_regfile;
  localparam int N = 8;
  localparam logic [31:0] TXG = 32'h0000_00FF;
  localparam logic [31:0] RXG = 32'h0000_FF00;
  localparam logic [31:0] ERG = 32'hFFFF_0000;
  localparam logic [31:0] IDV = 32'h4D41_0100;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic          rst = 1'b1, bus_en = 1'b0, bus_we = 1'b0;
  logic [7:0]    bus_addr = '0;
  logic [31:0]   bus_wdata = '0, evt_set = '0;
  logic [N-1:0]  txh_set = '0, rxh_set = '0;
  logic [31:0]   bus_rdata, ctrl_word, cmd_word;
  logic          tx_irq, rx_irq, err_irq;
  logic [N-1:0]  tx_restart, rx_restart;
  logic [32*N-1:0] tx_ring_ptr, rx_ring_ptr;

  dmac_regfile dut (
    .clk(clk), .rst(rst), .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .evt_set(evt_set),
    .tx_halt_set(txh_set), .rx_halt_set(rxh_set), .tx_irq(tx_irq), .rx_irq(rx_irq),
    .err_irq(err_irq), .tx_restart(tx_restart), .rx_restart(rx_restart),
    .tx_ring_ptr(tx_ring_ptr), .rx_ring_ptr(rx_ring_ptr),
    .ctrl_word(ctrl_word), .cmd_word(cmd_word)
  );

  // behavioural reference state
  logic [31:0] m_evt, m_msk, m_ctrl, m_cmd;
  logic [N-1:0] m_txh, m_rxh, e_txr, e_rxr;
  logic [31:0] m_txb [N];
  logic [31:0] m_txp [N];
  logic [31:0] m_rxb [N];
  logic [31:0] m_rxp [N];

  int vectors = 0;
  int bad = 0;
  bit done = 1'b0;
  string phase = "R1";

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s [%s] got %h expected %h", tag, phase, act, exp);
    end
  endtask

  function automatic logic [31:0] model_read(input int idx);
    logic [31:0] v;
    int g, r;
    v = '0;
    g = idx / 8;
    r = idx % 8;
    case (idx)
      0: v = m_evt;
      1: v = m_msk;
      2: v = m_ctrl;
      3: for (int k = 0; k < N; k++) v[31-k] = m_txh[k];
      4: for (int k = 0; k < N; k++) v[23-k] = m_rxh[k];
      6: v = IDV;
      default: begin
        if (r < N) begin
          if (g == 1) v = m_txb[r];
          else if (g == 2) v = m_txp[r];
          else if (g == 3) v = m_rxb[r];
          else if (g == 4) v = m_rxp[r];
        end
      end
    endcase
    return v;
  endfunction

  function automatic string read_tag(input int idx);
    if (idx == 0) return "R2 evt read";
    if (idx == 1) return "R3 mask read";
    if (idx == 2 || idx == 5) return "R7 ctrl/cmd read";
    if (idx == 3) return "R4 txstat read";
    if (idx == 4) return "R5 rxstat read";
    if (idx >= 8 && idx < 40) return "R6 ring read";
    return "R8 id/unmapped read";
  endfunction

  // advance the model by one clock edge using the inputs now driven
  task automatic model_edge();
    int idx;
    bit wr;
    logic [31:0] w;
    idx = int'(bus_addr >> 2);
    wr  = bus_en && bus_we;
    w   = bus_wdata;
    if (rst) begin
      m_evt = '0; m_msk = '0; m_ctrl = '0; m_cmd = '0;
      m_txh = '0; m_rxh = '0; e_txr = '0; e_rxr = '0;
      for (int r = 0; r < N; r++) begin
        m_txb[r] = '0; m_txp[r] = '0; m_rxb[r] = '0; m_rxp[r] = '0;
      end
    end else begin
      m_evt = (m_evt & ~((wr && idx == 0) ? w : 32'h0)) | evt_set;
      if (wr && idx == 1) m_msk  = w;
      if (wr && idx == 2) m_ctrl = w;
      if (wr && idx == 5) m_cmd  = w;
      for (int r = 0; r < N; r++) begin
        bit tc, rc;
        tc = wr && idx == 3 && w[31-r];
        rc = wr && idx == 4 && w[23-r];
        e_txr[r] = tc;
        e_rxr[r] = rc && !m_rxh[r];
        m_txh[r] = (m_txh[r] && !tc) || txh_set[r];
        m_rxh[r] = (m_rxh[r] && !rc) || rxh_set[r];
        if (wr && idx == 8 + r)  begin m_txb[r] = w & ~32'h7; m_txp[r] = w & ~32'h7; end
        if (wr && idx == 24 + r) begin m_rxb[r] = w & ~32'h7; m_rxp[r] = w & ~32'h7; end
      end
    end
  endtask

  task automatic step();
    int idx;
    model_edge();
    @(posedge clk);
    @(negedge clk);
    idx = int'(bus_addr >> 2);
    chk(read_tag(idx), bus_rdata, bus_en ? model_read(idx) : 32'h0);
    chk("R3 tx_irq",  {31'h0, tx_irq},  {31'h0, |(m_evt & m_msk & TXG)});
    chk("R3 rx_irq",  {31'h0, rx_irq},  {31'h0, |(m_evt & m_msk & RXG)});
    chk("R3 err_irq", {31'h0, err_irq}, {31'h0, |(m_evt & m_msk & ERG)});
    chk("R4 tx_restart", {24'h0, tx_restart}, {24'h0, e_txr});
    chk("R5 rx_restart", {24'h0, rx_restart}, {24'h0, e_rxr});
    for (int r = 0; r < N; r++) begin
      chk("R6 tx_ring_ptr", tx_ring_ptr[r*32 +: 32], m_txp[r]);
      chk("R6 rx_ring_ptr", rx_ring_ptr[r*32 +: 32], m_rxp[r]);
    end
    chk("R7 ctrl_word", ctrl_word, m_ctrl);
    chk("R7 cmd_word",  cmd_word,  m_cmd);
  endtask

  task automatic idle();
    bus_en = 1'b0; bus_we = 1'b0; evt_set = '0; txh_set = '0; rxh_set = '0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    step();
    idle();
  endtask

  task automatic rd(input logic [7:0] a);
    bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
    step();
    idle();
  endtask

  initial begin
    int seed;
    // R1: reset
    phase = "R1";
    rst = 1'b1;
    repeat (3) step();
    rst = 1'b0;
    rd(8'h18);
    for (int i = 0; i < 6; i++) rd(8'(i * 4));
    rd(8'h40);

    // R2 / R3: events, mask, grouped interrupts
    phase = "R3";
    wr(8'h04, 32'hFFFF_FFFF);
    evt_set = 32'h0001_0101; step(); idle();
    rd(8'h00);
    phase = "R2";
    wr(8'h00, 32'h0000_0001);
    rd(8'h00);
    evt_set = 32'h0001_0000;
    bus_en = 1'b1; bus_we = 1'b1; bus_addr = 8'h00; bus_wdata = 32'h0001_0100;
    step(); idle();
    rd(8'h00);
    phase = "R3";
    wr(8'h04, 32'h0000_FF00);
    wr(8'h04, 32'h0000_0000);
    wr(8'h00, 32'hFFFF_FFFF);

    // R4: transmit halts and restarts
    phase = "R4";
    txh_set = 8'hA5; step(); idle();
    rd(8'h0C);
    wr(8'h0C, 32'h8000_0000);
    rd(8'h0C);
    wr(8'h0C, 32'hFF00_0000);
    rd(8'h0C);

    // R5: receive halts, pulse only on idle flag
    phase = "R5";
    rxh_set = 8'h0F; step(); idle();
    rd(8'h10);
    wr(8'h10, 32'h00FF_0000);
    rd(8'h10);
    wr(8'h10, 32'h0080_0000);

    // R10: set versus clear on the same flag
    phase = "R10";
    txh_set = 8'h02;
    bus_en = 1'b1; bus_we = 1'b1; bus_addr = 8'h0C; bus_wdata = 32'h4000_0000;
    step(); idle();
    rd(8'h0C);
    rxh_set = 8'h01;
    bus_en = 1'b1; bus_we = 1'b1; bus_addr = 8'h10; bus_wdata = 32'h0080_0000;
    step(); idle();
    rd(8'h10);

    // R6: base writes load pointers
    phase = "R6";
    for (int r = 0; r < N; r++) begin
      wr(8'((8 + r) * 4), 32'h1000_0007 + 32'(r) * 32'h111);
      rd(8'((8 + r) * 4));
      rd(8'((16 + r) * 4));
      wr(8'((24 + r) * 4), 32'h2000_0005 + 32'(r) * 32'h222);
      rd(8'((24 + r) * 4));
      rd(8'((32 + r) * 4));
    end

    // R7: control and write-only command
    phase = "R7";
    wr(8'h08, 32'hCAFE_0011);
    rd(8'h08);
    wr(8'h14, 32'h1234_5678);
    rd(8'h14);

    // R8: read-only and unmapped locations
    phase = "R8";
    wr(8'h18, 32'h0);
    rd(8'h18);
    wr(8'h1C, 32'hFFFF_FFFF);
    rd(8'h1C);
    wr(8'hA0, 32'hFFFF_FFFF);
    rd(8'hA0);
    wr(8'h40, 32'hDEAD_BEEF);
    rd(8'h40);
    wr(8'h80, 32'hDEAD_BEEF);
    rd(8'h80);

    // R9: low address bits ignored
    phase = "R9";
    wr(8'h05, 32'h00FF_00FF);
    rd(8'h07);
    wr(8'h0B, 32'h0000_0ABC);
    rd(8'h09);

    // mixed traffic
    phase = "mix";
    seed = $urandom(32'h5EED);
    for (int c = 0; c < 3000; c++) begin
      logic [31:0] r;
      r = $urandom;
      bus_en    = r[0] | r[1];
      bus_we    = r[2];
      bus_addr  = {r[15:10], r[19:18]};
      bus_wdata = (r[21:20] == 2'b00) ? 32'hFFFF_FFFF : $urandom;
      evt_set   = r[16] ? ($urandom & $urandom & $urandom) : 32'h0;
      txh_set   = r[17] ? 8'($urandom) : 8'h0;
      rxh_set   = r[22] ? 8'($urandom) : 8'h0;
      rst       = (r[31:24] == 8'hFF);
      step();
    end
    rst = 1'b0;
    idle();
    step();

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      bad++;
      $display("FAIL watchdog [%s] got running expected finished", phase);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, bad);
      $finish;
    end
  end
endmodule